// File: doc/BRIEF.md
# FIFO Threshold DMA Request Monitor

This block watches the fill level of the data FIFO in an SD/MMC host controller. It compares that level with two programmable thresholds, taking the transfer direction into account. When the FIFO is filling toward the host, a level above the almost-full threshold means data is waiting to be drained. When the FIFO is feeding the card, a level below the almost-empty threshold means more data is needed. The FIFO storage, the register file and the card interface are outside this block.

Each direction has its own enable bit, and that bit decides where a threshold event goes. With the enable set, the event raises a DMA request line for that direction. With the enable clear, it raises a level status flag that feeds the interrupt logic. All four outputs are registered, so they follow their inputs one clock later and do not glitch. When no transfer is running and the FIFO is empty, all four outputs are held low.

The thresholds and enables are loaded from one 16-bit configuration word, written with a single-cycle strobe.

Top module: `fifo_level_dma_mon`

## Requirements
- R1: After reset, all four outputs are low, the almost-full threshold is 31, the almost-empty threshold is 0, and both DMA enables are clear.
- R2: When `xfer_active` is low and `fifo_count` is 0, all four outputs are low in the next cycle, whatever the thresholds, enables or direction.
- R3: A receive event occurs when `xfer_to_host` is 1 and `fifo_count` is strictly greater than the almost-full threshold.
- R4: A transmit event occurs when `xfer_to_host` is 0 and `fifo_count` is strictly less than the almost-empty threshold. This also applies with a transfer active and a count of 0, and with no transfer active and a nonzero count.
- R5: On a receive event, if receive DMA is enabled, `rx_dma_req` goes high and `rx_level_flag` stays low. Otherwise `rx_level_flag` goes high and `rx_dma_req` stays low.
- R6: On a transmit event, if transmit DMA is enabled, `tx_dma_req` goes high and `tx_level_flag` stays low. Otherwise `tx_level_flag` goes high and `tx_dma_req` stays low.
- R7: When a direction has no event, including when the transfer runs the other way, its request and flag are both low.
- R8: When `cfg_wr` is high, the configuration is loaded from `cfg_word`. Bit 15 is the receive DMA enable, bits 12:8 are the almost-full threshold, bit 7 is the transmit DMA enable, and bits 4:0 are the almost-empty threshold. Bits 14:13 and 6:5 are ignored.
- R9: A configuration write that sets a DMA enable clears that direction's level flag in the next cycle.
- R10: Each output reflects the inputs and configuration of the previous clock edge. A change does not reach the outputs before the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fifo_count | input | 6 | Number of FIFO entries in use, 0 to 32 |
| xfer_active | input | 1 | A data transfer is in progress |
| xfer_to_host | input | 1 | 1: card-to-host direction, 0: host-to-card direction |
| cfg_wr | input | 1 | Strobe that loads the configuration word |
| cfg_word | input | 16 | Configuration word (see R8) |
| rx_dma_req | output | 1 | Receive DMA request |
| tx_dma_req | output | 1 | Transmit DMA request |
| rx_level_flag | output | 1 | Almost-full level status flag |
| tx_level_flag | output | 1 | Almost-empty level status flag |

## Verification
The bench builds the block with its default FIFO depth of 32. With this depth the count can reach 32, one more than the largest almost-full threshold of 31. That makes a receive event reachable with the reset thresholds. Directed steps check each threshold one below, at, and one above its level. A long run of random counts, directions and configuration writes, including writes with the ignored bits set, is then compared cycle by cycle against a behavioural model.

// File: rtl/fifo_mon_pkg.sv
package fifo_mon_pkg;
  // Threshold field width and configuration word layout.
  localparam int LVL_W      = 5;
  localparam int CFG_W      = 16;
  localparam int RX_EN_BIT  = 15;
  localparam int AF_LSB     = 8;
  localparam int TX_EN_BIT  = 7;
  localparam int AE_LSB     = 0;
  localparam logic [LVL_W-1:0] AF_RESET = '1;
  localparam logic [LVL_W-1:0] AE_RESET = '0;

  typedef struct packed {
    logic             rx_dma_en;
    logic [LVL_W-1:0] af_level;
    logic             tx_dma_en;
    logic [LVL_W-1:0] ae_level;
  } mon_cfg_t;

  function automatic mon_cfg_t decode_cfg(input logic [CFG_W-1:0] w);
    mon_cfg_t c;
    c.rx_dma_en = w[RX_EN_BIT];
    c.af_level  = w[AF_LSB +: LVL_W];
    c.tx_dma_en = w[TX_EN_BIT];
    c.ae_level  = w[AE_LSB +: LVL_W];
    return c;
  endfunction
endpackage

// File: rtl/fifo_mon_cfg_reg.sv
module fifo_mon_cfg_reg
  import fifo_mon_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_wr,
  input  logic [CFG_W-1:0] cfg_word,
  output mon_cfg_t         cfg_eff
);
  mon_cfg_t cfg_q;
  mon_cfg_t cfg_d;

  // A write takes effect in the same cycle it is presented.
  always_comb begin
    cfg_d = cfg_q;
    if (cfg_wr) cfg_d = decode_cfg(cfg_word);
  end

  assign cfg_eff = cfg_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q.rx_dma_en <= 1'b0;
      cfg_q.af_level  <= AF_RESET;
      cfg_q.tx_dma_en <= 1'b0;
      cfg_q.ae_level  <= AE_RESET;
    end else if (cfg_wr) begin
      cfg_q <= cfg_d;
    end
  end

  AST_CFG_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_wr |=> (cfg_q.af_level == $past(cfg_word[AF_LSB +: LVL_W]))
            && (cfg_q.ae_level == $past(cfg_word[AE_LSB +: LVL_W]))); // R8
  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_wr |=> $stable(cfg_q)); // R8
endmodule

// File: rtl/fifo_mon_lane.sv
module fifo_mon_lane #(
  parameter int CNT_W = 6,
  parameter int LVL_W = 5,
  parameter bit IS_RX = 1'b1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] fifo_count,
  input  logic             xfer_to_host,
  input  logic             quiet,
  input  logic [LVL_W-1:0] level,
  input  logic             dma_en,
  output logic             dma_req,
  output logic             thr_flag
);
  logic [CNT_W-1:0] level_ext;
  logic             evt;
  logic             req_d, flag_d;
  logic             upd_en;

  assign level_ext = CNT_W'(level);

  generate
    if (IS_RX) begin : g_rx
      assign evt = xfer_to_host && (fifo_count > level_ext);
    end else begin : g_tx
      assign evt = !xfer_to_host && (fifo_count < level_ext);
    end
  endgenerate

  always_comb begin
    req_d  = 1'b0;
    flag_d = 1'b0;
    if (!quiet && evt) begin
      req_d  = dma_en;
      flag_d = !dma_en;
    end
  end

  assign upd_en = (req_d != dma_req) || (flag_d != thr_flag);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dma_req  <= 1'b0;
      thr_flag <= 1'b0;
    end else if (upd_en) begin
      dma_req  <= req_d;
      thr_flag <= flag_d;
    end
  end

  AST_REQ_FLAG_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(dma_req && thr_flag)); // R5
  AST_QUIET_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    quiet |=> (!dma_req && !thr_flag)); // R2
  AST_WRONG_DIR_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_to_host != IS_RX) |=> (!dma_req && !thr_flag)); // R7
endmodule

// File: rtl/fifo_level_dma_mon.sv
module fifo_level_dma_mon
  import fifo_mon_pkg::*;
#(
  parameter int FIFO_DEPTH = 32,
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] fifo_count,
  input  logic             xfer_active,
  input  logic             xfer_to_host,
  input  logic             cfg_wr,
  input  logic [CFG_W-1:0] cfg_word,
  output logic             rx_dma_req,
  output logic             tx_dma_req,
  output logic             rx_level_flag,
  output logic             tx_level_flag
);
  localparam int NLANE = 2;

  mon_cfg_t         cfg_eff;
  logic             quiet;
  logic [NLANE-1:0] lane_req, lane_flag;
  logic [NLANE-1:0] lane_en;
  logic [LVL_W-1:0] lane_lvl [NLANE];

  fifo_mon_cfg_reg u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_wr   (cfg_wr),
    .cfg_word (cfg_word),
    .cfg_eff  (cfg_eff)
  );

  assign quiet = !xfer_active && (fifo_count == '0);

  // Lane 0 handles receive, lane 1 handles transmit.
  assign lane_en[0]  = cfg_eff.rx_dma_en;
  assign lane_lvl[0] = cfg_eff.af_level;
  assign lane_en[1]  = cfg_eff.tx_dma_en;
  assign lane_lvl[1] = cfg_eff.ae_level;

  generate
    for (genvar i = 0; i < NLANE; i++) begin : g_lane
      fifo_mon_lane #(
        .CNT_W (CNT_W),
        .LVL_W (LVL_W),
        .IS_RX (i == 0)
      ) u_lane (
        .clk          (clk),
        .rst_n        (rst_n),
        .fifo_count   (fifo_count),
        .xfer_to_host (xfer_to_host),
        .quiet        (quiet),
        .level        (lane_lvl[i]),
        .dma_en       (lane_en[i]),
        .dma_req      (lane_req[i]),
        .thr_flag     (lane_flag[i])
      );
    end
  endgenerate

  assign rx_dma_req    = lane_req[0];
  assign tx_dma_req    = lane_req[1];
  assign rx_level_flag = lane_flag[0];
  assign tx_level_flag = lane_flag[1];

  AST_RX_EN_CLEARS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_word[RX_EN_BIT]) |=> !rx_level_flag); // R9
  AST_TX_EN_CLEARS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_word[TX_EN_BIT]) |=> !tx_level_flag); // R9
  AST_DIRS_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !((rx_dma_req || rx_level_flag) && (tx_dma_req || tx_level_flag))); // R7
endmodule

// File: tb/fifo_level_dma_mon_bench.sv
module fifo_level_dma_mon_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [5:0]  fifo_count;
  logic        xfer_active, xfer_to_host, cfg_wr;
  logic [15:0] cfg_word;
  logic        rx_dma_req, tx_dma_req, rx_level_flag, tx_level_flag;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;
  bit cmp_en  = 1'b0;

  // reference model state
  int m_af, m_ae;
  bit m_rxen, m_txen;
  bit e_rxr, e_txr, e_rxf, e_txf;

  always #2 clk = ~clk;

  fifo_level_dma_mon u_fifo_level_dma_mon (
    .clk(clk), .rst_n(rst_n), .fifo_count(fifo_count),
    .xfer_active(xfer_active), .xfer_to_host(xfer_to_host),
    .cfg_wr(cfg_wr), .cfg_word(cfg_word),
    .rx_dma_req(rx_dma_req), .tx_dma_req(tx_dma_req),
    .rx_level_flag(rx_level_flag), .tx_level_flag(tx_level_flag)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_af = 31; m_ae = 0; m_rxen = 0; m_txen = 0;
      e_rxr = 0; e_txr = 0; e_rxf = 0; e_txf = 0;
    end else begin
      bit rx_ev, tx_ev, q;
      if (cfg_wr) begin
        m_rxen = cfg_word[15];
        m_af   = int'(cfg_word[12:8]);
        m_txen = cfg_word[7];
        m_ae   = int'(cfg_word[4:0]);
      end
      q     = !xfer_active && (fifo_count == 0);
      rx_ev = !q && xfer_to_host && (int'(fifo_count) > m_af);
      tx_ev = !q && !xfer_to_host && (int'(fifo_count) < m_ae);
      e_rxr = rx_ev && m_rxen;  e_rxf = rx_ev && !m_rxen;
      e_txr = tx_ev && m_txen;  e_txf = tx_ev && !m_txen;
    end
  end

  task automatic check4(input string tag, input bit rxr, input bit txr,
                        input bit rxf, input bit txf);
    n_tests++;
    if ({rx_dma_req, tx_dma_req, rx_level_flag, tx_level_flag} !== {rxr, txr, rxf, txf}) begin
      n_fail++;
      $display("FAIL %s: {rxreq,txreq,rxflag,txflag} actual %b%b%b%b expected %b%b%b%b",
               tag, rx_dma_req, tx_dma_req, rx_level_flag, tx_level_flag, rxr, txr, rxf, txf);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (rst_n && cmp_en) begin
      string tag;
      if (e_rxr || e_rxf) tag = "R5 model";
      else if (e_txr || e_txf) tag = "R6 model";
      else tag = "R7/R2 model";
      check4(tag, e_rxr, e_txr, e_rxf, e_txf);
    end
  end

  task automatic drive(input int cnt, input bit act, input bit dir);
    fifo_count = 6'(cnt); xfer_active = act; xfer_to_host = dir;
  endtask

  task automatic wcfg(input logic [15:0] w);
    cfg_wr = 1'b1; cfg_word = w;
  endtask

  task automatic step;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cfg_wr = 1'b0; cfg_word = '0;
    drive(5, 1, 1);
    repeat (3) @(negedge clk);
    check4("R1 reset outputs", 0, 0, 0, 0);
    rst_n = 1'b1;
    cmp_en = 1'b1;

    // R1 default thresholds: af=31, ae=0
    drive(31, 1, 1); step; check4("R1 af default 31, count 31", 0, 0, 0, 0);
    drive(32, 1, 1); step; check4("R3 count 32 > af 31", 0, 0, 1, 0);
    drive(0, 1, 0);  step; check4("R1 ae default 0 gives no tx event", 0, 0, 0, 0);

    // R8: af=5, ae=10, ignored bits 14,13,6,5 set, enables clear
    wcfg(16'h656A);
    drive(5, 1, 1);  step; check4("R8 af=5 count 5", 0, 0, 0, 0);
    drive(6, 1, 1);  step; check4("R3 R8 count 6 > af 5", 0, 0, 1, 0);
    drive(10, 1, 0); step; check4("R8 ae=10 count 10", 0, 0, 0, 0);
    drive(9, 1, 0);  step; check4("R4 count 9 < ae 10", 0, 0, 0, 1);

    // R10 latency
    drive(10, 1, 0); #1;
    check4("R10 output held before edge", 0, 0, 0, 1);
    step; check4("R10 output updated after edge", 0, 0, 0, 0);

    // R9 and R6: enabling tx DMA clears tx flag
    drive(9, 1, 0); step; check4("R6 flag path", 0, 0, 0, 1);
    wcfg(16'h058A); step; check4("R9 R6 tx enable clears flag, raises req", 0, 1, 0, 0);

    // R5 rx DMA
    wcfg(16'h858A); drive(6, 1, 1); step;
    check4("R5 rx dma request", 1, 0, 0, 0);
    check4("R7 tx quiet in rx direction", 1, 0, 0, 0);

    // R2 quiet, R4 corner cases
    wcfg(16'h050A);
    drive(0, 0, 0); step; check4("R2 idle empty forces quiet", 0, 0, 0, 0);
    drive(0, 1, 0); step; check4("R4 active with empty fifo", 0, 0, 0, 1);
    drive(3, 0, 0); step; check4("R4 idle with nonzero count", 0, 0, 0, 1);
    drive(0, 0, 1); step; check4("R2 idle empty rx dir", 0, 0, 0, 0);
    drive(0, 1, 1); step; check4("R7 rx dir, no event", 0, 0, 0, 0);

    // random run against the model
    for (int i = 0; i < 3000; i++) begin
      drive(int'($urandom_range(0, 32)), ($urandom_range(0, 7) != 0), $urandom_range(0, 1) == 1);
      if ($urandom_range(0, 15) == 0) wcfg(16'($urandom()));
      step;
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule